// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Flags

This block is the watchdog of a small microcontroller. It counts ticks from one of two sources: a dedicated watchdog oscillator, or the instruction clock (system clock divided by four). The ticks pass first through a fixed power-of-two divider and then through a binary prescaler whose ratio software picks with a 3-bit field. If software does not clear the watchdog in time, the block asks the chip to reset.

The block tracks whether the CPU is halted. An overflow during normal running asks for a full chip reset. An overflow while halted asks only for a warm reset, which clears the program counter and stack pointer and wakes the CPU. Two flags record what happened. The timeout flag is set by an overflow. The power-down flag is set by entering halt. Both are cleared by power-on reset and by the clear-watchdog strobe, and entering halt also clears the timeout flag. From the two flags, software can tell apart a power-up, a timeout while running, and a timeout that woke the CPU from halt.

A build-time enable option turns the watchdog off. When it is off, the count stays at zero and no reset request is ever made.

Top module: `wdt_rcause`

## Requirements
- R1: `src_sel`=1 counts `osc_tick` pulses and `src_sel`=0 counts `icyc_tick` pulses. Pulses on the source that is not selected have no effect on the count.
- R2: After a clear, the overflow comes on exactly the 2^FIX_LOG2 × 2^k-th selected tick, where k is the value of `ratio`. Code 0 gives 1:1 and code 7 gives 1:128.
- R3: `ratio` is used on every tick. A change of `ratio` takes effect at once, using the prescaler count already gathered, and does not restart the count.
- R4: `clr_wdt` zeroes the count and clears both flags on the next edge. It also ends the halted state. It takes priority over `halt_enter` and over an overflow in the same cycle, so no request follows it.
- R5: `halt_enter` zeroes the count, sets the power-down flag, clears the timeout flag and puts the block in the halted state.
- R6: An overflow while not halted drives `full_rst_req` high for exactly one cycle, beginning at the edge that takes the overflowing tick. At that same edge it sets `to_flag`, leaves `pd_flag` unchanged and restarts the count from zero.
- R7: An overflow while halted drives `warm_rst_req` high for one cycle and leaves `full_rst_req` low. It sets `to_flag`, leaves `pd_flag` at 1 and ends the halted state.
- R8: `wake_evt` ends the halted state and changes neither the flags nor the count. A later overflow then gives a full request.
- R9: Power-on reset (`rst_n` low) clears both flags, both requests, the count and the halted state.
- R10: While `en_opt` is 0, the count is held at zero and no request is made. When `en_opt` returns to 1, counting starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the ticks are one-cycle enables in this clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| en_opt | input | 1 | Build-time enable option for the watchdog |
| src_sel | input | 1 | Count source: 1 = watchdog oscillator, 0 = instruction clock |
| osc_tick | input | 1 | One-cycle pulse per watchdog oscillator period |
| icyc_tick | input | 1 | One-cycle pulse per instruction cycle |
| ratio | input | RATIO_W | Prescaler code k, which gives division 2^k |
| clr_wdt | input | 1 | Clear-watchdog strobe |
| halt_enter | input | 1 | Strobe raised when the CPU enters halt |
| wake_evt | input | 1 | Strobe raised when halt ends for a reason other than the watchdog |
| full_rst_req | output | 1 | One-cycle request for a full chip reset |
| warm_rst_req | output | 1 | One-cycle request to reset only the program counter and stack pointer |
| to_flag | output | 1 | Timeout flag |
| pd_flag | output | 1 | Power-down flag |

## Verification
The bench builds the block with FIX_LOG2=2 and the default RATIO_W=3. The fixed stage then divides by four, and the longest timeout (code 7) is 512 ticks rather than 32768. This makes every ratio code reachable in a short run, including the 1:128 end. It also makes it cheap to check the exact tick of each overflow and to step across prescaler boundaries after a mid-count ratio change. The priority cases are checked by putting a clear and an overflow on the same tick, and a clear and a halt entry in the same cycle.

// File: rtl/wdt_rcause.sv
module wdt_rcause #(
  parameter int FIX_LOG2 = 8,
  parameter int RATIO_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_opt,
  input  logic               src_sel,
  input  logic               osc_tick,
  input  logic               icyc_tick,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               clr_wdt,
  input  logic               halt_enter,
  input  logic               wake_evt,
  output logic               full_rst_req,
  output logic               warm_rst_req,
  output logic               to_flag,
  output logic               pd_flag
);
  localparam int PRE_W = (1 << RATIO_W) - 1;

  logic [FIX_LOG2-1:0] fix_cnt;
  logic [PRE_W-1:0]    pre_cnt;
  logic [PRE_W-1:0]    pre_mask;
  logic                halted;
  logic                tick;
  logic                fix_carry;
  logic                expire;

  assign tick      = en_opt & (src_sel ? osc_tick : icyc_tick);
  assign fix_carry = tick & (&fix_cnt);
  assign pre_mask  = ~({PRE_W{1'b1}} << ratio);
  assign expire    = fix_carry & ((pre_cnt & pre_mask) == pre_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fix_cnt      <= '0;
      pre_cnt      <= '0;
      halted       <= 1'b0;
      to_flag      <= 1'b0;
      pd_flag      <= 1'b0;
      full_rst_req <= 1'b0;
      warm_rst_req <= 1'b0;
    end else begin
      full_rst_req <= 1'b0;
      warm_rst_req <= 1'b0;
      if (clr_wdt) begin
        fix_cnt <= '0;
        pre_cnt <= '0;
        to_flag <= 1'b0;
        pd_flag <= 1'b0;
        halted  <= 1'b0;
      end else if (halt_enter) begin
        fix_cnt <= '0;
        pre_cnt <= '0;
        to_flag <= 1'b0;
        pd_flag <= 1'b1;
        halted  <= 1'b1;
      end else if (expire) begin
        fix_cnt <= '0;
        pre_cnt <= '0;
        to_flag <= 1'b1;
        halted  <= 1'b0;
        if (halted) warm_rst_req <= 1'b1;
        else        full_rst_req <= 1'b1;
      end else begin
        if (!en_opt) begin
          fix_cnt <= '0;
          pre_cnt <= '0;
        end else if (tick) begin
          fix_cnt <= fix_cnt + 1'b1;
          if (fix_carry) pre_cnt <= pre_cnt + 1'b1;
        end
        if (wake_evt) halted <= 1'b0;
      end
    end
  end
endmodule

module wdt_rcause_chk (
  input logic clk,
  input logic rst_n,
  input logic en_opt,
  input logic clr_wdt,
  input logic halt_enter,
  input logic full_rst_req,
  input logic warm_rst_req,
  input logic to_flag,
  input logic pd_flag
);
  a_r6_full_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    full_rst_req |=> !full_rst_req);

  a_r7_warm_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst_req |=> !warm_rst_req);

  a_r7_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_rst_req && warm_rst_req));

  a_r6_full_sets_to: assert property (@(posedge clk) disable iff (!rst_n)
    full_rst_req |-> to_flag);

  a_r7_warm_flags: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst_req |-> (to_flag && pd_flag));

  a_r4_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_wdt) |-> (!to_flag && !pd_flag && !full_rst_req && !warm_rst_req));

  a_r5_halt_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $past(halt_enter && !clr_wdt) |-> (pd_flag && !to_flag));

  a_r10_no_req_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (full_rst_req || warm_rst_req) |-> $past(en_opt));
endmodule

bind wdt_rcause wdt_rcause_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_opt(en_opt), .clr_wdt(clr_wdt),
  .halt_enter(halt_enter), .full_rst_req(full_rst_req),
  .warm_rst_req(warm_rst_req), .to_flag(to_flag), .pd_flag(pd_flag)
);

// File: tb/wdt_rcause_test.sv
module wdt_rcause_test;
  localparam int FIX_LOG2 = 2;
  localparam int RATIO_W  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_opt = 1'b1;
  logic src_sel = 1'b0;
  logic osc_tick = 1'b0;
  logic icyc_tick = 1'b0;
  logic [RATIO_W-1:0] ratio = '0;
  logic clr_wdt = 1'b0;
  logic halt_enter = 1'b0;
  logic wake_evt = 1'b0;
  logic full_rst_req, warm_rst_req, to_flag, pd_flag;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int full_seen = 0;
  int warm_seen = 0;

  always #4 clk = ~clk;

  wdt_rcause #(.FIX_LOG2(FIX_LOG2), .RATIO_W(RATIO_W)) uut (
    .clk(clk), .rst_n(rst_n), .en_opt(en_opt), .src_sel(src_sel),
    .osc_tick(osc_tick), .icyc_tick(icyc_tick), .ratio(ratio),
    .clr_wdt(clr_wdt), .halt_enter(halt_enter), .wake_evt(wake_evt),
    .full_rst_req(full_rst_req), .warm_rst_req(warm_rst_req),
    .to_flag(to_flag), .pd_flag(pd_flag)
  );

  always @(posedge clk) begin
    if (full_rst_req) full_seen++;
    if (warm_rst_req) warm_seen++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic o, input logic i, input logic c,
                       input logic h, input logic w);
    osc_tick = o; icyc_tick = i; clr_wdt = c; halt_enter = h; wake_evt = w;
    @(negedge clk);
    osc_tick = 0; icyc_tick = 0; clr_wdt = 0; halt_enter = 0; wake_evt = 0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) drive(src_sel, !src_sel, 0, 0, 0);
  endtask

  task automatic idle(); drive(0, 0, 0, 0, 0); endtask
  task automatic clear(); drive(0, 0, 1, 0, 0); endtask

  function automatic int period(input int r);
    return (1 << FIX_LOG2) << r;
  endfunction

  task automatic t_reset();
    chk("R9 to_flag after reset", to_flag, 0);
    chk("R9 pd_flag after reset", pd_flag, 0);
    chk("R9 requests after reset", full_rst_req | warm_rst_req, 0);
  endtask

  task automatic t_basic_icyc();
    src_sel = 0; ratio = 0; clear();
    full_seen = 0;
    ticks(period(0) - 1);
    chk("R2 no overflow before period", full_seen + full_rst_req, 0);
    ticks(1);
    chk("R6 full request on last tick", full_rst_req, 1);
    chk("R6 warm low on normal overflow", warm_rst_req, 0);
    chk("R6 to_flag set", to_flag, 1);
    chk("R6 pd_flag unchanged", pd_flag, 0);
    idle();
    chk("R6 full request one cycle", full_rst_req, 0);
    full_seen = 0;
    ticks(period(0) - 1);
    chk("R6 count restarted after overflow", full_seen + full_rst_req, 0);
    ticks(1);
    chk("R6 second overflow one period later", full_rst_req, 1);
    idle();
  endtask

  task automatic t_osc_select();
    src_sel = 1; ratio = 3; clear();
    full_seen = 0;
    for (int k = 0; k < 100; k++) drive(0, 1, 0, 0, 0);
    ticks(period(3) - 1);
    chk("R1 unselected ticks ignored", full_seen + full_rst_req, 0);
    ticks(1);
    chk("R1 osc source overflow at ratio 3", full_rst_req, 1);
    idle();
  endtask

  task automatic t_ratio_ends();
    src_sel = 0; ratio = 7; clear();
    full_seen = 0;
    ticks(period(7) - 1);
    chk("R2 ratio code 7 not yet", full_seen + full_rst_req, 0);
    ticks(1);
    chk("R2 ratio code 7 is 1:128", full_rst_req, 1);
    idle();
  endtask

  task automatic t_clear_mid();
    src_sel = 0; ratio = 0; clear();
    ticks(3);
    clear();
    chk("R4 clear drops to_flag", to_flag, 0);
    full_seen = 0;
    ticks(3);
    chk("R4 count zeroed by clear", full_seen + full_rst_req, 0);
    ticks(1);
    chk("R4 full period after clear", full_rst_req, 1);
    idle();
    ticks(3);
    full_seen = 0;
    drive(0, 1, 1, 0, 0);
    chk("R4 clear beats overflow", full_rst_req, 0);
    chk("R4 clear beats overflow flag", to_flag, 0);
    drive(0, 0, 1, 1, 0);
    chk("R4 clear beats halt pd", pd_flag, 0);
    idle();
  endtask

  task automatic t_ratio_live();
    src_sel = 0; ratio = 2; clear();
    full_seen = 0;
    ticks(12);
    ratio = 1;
    ticks(3);
    chk("R3 no overflow before carry", full_seen + full_rst_req, 0);
    ticks(1);
    chk("R3 new ratio uses kept count", full_rst_req, 1);
    idle();
  endtask

  task automatic t_halt();
    src_sel = 0; ratio = 0; clear();
    ticks(3);
    drive(0, 0, 0, 1, 0);
    chk("R5 halt sets pd", pd_flag, 1);
    chk("R5 halt clears to", to_flag, 0);
    full_seen = 0; warm_seen = 0;
    ticks(3);
    chk("R5 halt zeroed count", full_seen + warm_seen + warm_rst_req, 0);
    ticks(1);
    chk("R7 warm request while halted", warm_rst_req, 1);
    chk("R7 no full while halted", full_rst_req, 0);
    chk("R7 to set", to_flag, 1);
    chk("R7 pd kept", pd_flag, 1);
    idle();
    chk("R7 warm one cycle", warm_rst_req, 0);
    full_seen = 0;
    ticks(period(0));
    chk("R7 halted state ended", full_rst_req, 1);
    idle();
  endtask

  task automatic t_wake();
    src_sel = 0; ratio = 0; clear();
    drive(0, 0, 0, 1, 0);
    ticks(2);
    drive(0, 0, 0, 0, 1);
    chk("R8 wake keeps pd", pd_flag, 1);
    chk("R8 wake keeps to", to_flag, 0);
    ticks(1);
    chk("R8 wake kept count", full_rst_req | warm_rst_req, 0);
    ticks(1);
    chk("R8 full after wake", full_rst_req, 1);
    chk("R8 no warm after wake", warm_rst_req, 0);
    idle();
  endtask

  task automatic t_disable();
    src_sel = 0; ratio = 0; clear();
    ticks(2);
    en_opt = 0;
    full_seen = 0; warm_seen = 0;
    ticks(50);
    chk("R10 no request when disabled", full_seen + warm_seen + full_rst_req, 0);
    en_opt = 1;
    ticks(period(0) - 1);
    chk("R10 count restarts from zero", full_seen + full_rst_req, 0);
    ticks(1);
    chk("R10 overflow after re-enable", full_rst_req, 1);
    idle();
  endtask

  task automatic t_por_again();
    src_sel = 0; ratio = 0; clear();
    drive(0, 0, 0, 1, 0);
    ticks(period(0));
    rst_n = 0;
    idle();
    chk("R9 reset clears to", to_flag, 0);
    chk("R9 reset clears pd", pd_flag, 0);
    rst_n = 1;
    idle();
    ticks(period(0));
    chk("R9 reset ends halted", full_rst_req, 1);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic_icyc();
    t_osc_select();
    t_ratio_ends();
    t_clear_mid();
    t_ratio_live();
    t_halt();
    t_wake();
    t_disable();
    t_por_again();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule